// File: doc/BRIEF.md
# Single-Frame Network Interface Controller

This peripheral connects a host register bus to a byte-wide network link. It holds at most one received frame and one frame being built for transmission. Each frame sits in its own on-chip byte buffer. The host reads the received frame one byte at a time through a data port. It loads an outgoing frame by first writing a byte count and then writing that many bytes to a second data port. When the final byte arrives, the block launches the frame on its transmit stream with no further command.

One interrupt-control register carries three flags: transmit-complete, receive-complete and a self-test flag. A level interrupt stays high while any of the three is set. A single busy flag stops new frames from being taken in. Busy is raised by every completion event. It is recomputed from the flags each time the host writes the interrupt-control register. The host therefore releases the receiver by clearing the completion flags.

Setting only the self-test bit in a control write soft-resets the block and leaves the self-test flag raised. That flag is cleared by the next read of the control register.

Top module: `frame_nic`

## Requirements
- R1: Reads return fixed values by 6-bit offset. Offset 0x00 returns 0x4D495053 and 0x04 returns 0x4E455430. Offset 0x08 returns busy in bit 0, 0x0C the receive count, 0x10 the transmit count and 0x14 the interrupt-control word. Offset 0x1C is the receive data port. Offsets 0x18 and 0x20 always read as zero.
- R2: Bus writes to offsets 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change no state.
- R3: A write to the transmit count at 0x10 stores the value when it is at most MAX_LEN and stores 0 otherwise. Every such write also returns the transmit write pointer to 0.
- R4: A write to 0x20 stores bits [7:0] at the write pointer and advances the pointer. When the pointer reaches the programmed count, the frame is launched. The count and pointer then return to 0, transmit-complete (bit 0) is set and busy becomes 1. Writes made while the count is 0 or the pointer has reached the count are dropped.
- R5: The transmit stream presents the bytes in the order they were written, with last high on the final byte only. Data and last are held while ready is low. Writes to 0x20 are ignored while a frame is still streaming out.
- R6: A frame is accepted only if its first byte arrives while busy is 0 and the receive count is below MAX_LEN. A frame that is not accepted is discarded through its last byte.
- R7: On the last byte of an accepted frame, the receive count becomes the frame length, the read pointer returns to 0, receive-complete (bit 1) is set and busy becomes 1.
- R8: Bytes beyond MAX_LEN in an incoming frame are not stored, and the receive count saturates at MAX_LEN.
- R9: A read of 0x1C with a nonzero receive count returns the next stored byte in bits [7:0], advances the read pointer and decrements the count. With a zero count the read returns 0 and changes nothing.
- R10: An interrupt-control write acts on at most one flag, taking the first matching case in this order. Bit 0 set clears only transmit-complete. Otherwise bit 1 set clears only receive-complete. Otherwise bit 31 set soft-resets the block and then sets the self-test flag (bit 31). A write of zero clears nothing.
- R11: After each interrupt-control write, busy equals 1 if any flag remains set and 0 otherwise.
- R12: A read of the interrupt-control register returns its value before the read, then clears bit 31.
- R13: The irq output is high exactly when at least one interrupt-control flag is set.
- R14: Hard reset and soft reset both clear the counts, pointers and flags, and both set busy to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| bus_addr | input | 6 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |
| rxs_valid | input | 1 | Incoming byte valid |
| rxs_data | input | 8 | Incoming byte |
| rxs_last | input | 1 | Incoming byte is the frame's last |
| txs_valid | output | 1 | Outgoing byte valid |
| txs_data | output | 8 | Outgoing byte |
| txs_last | output | 1 | Outgoing byte is the frame's last |
| txs_ready | input | 1 | Sink accepts the outgoing byte |

## Verification
Read data is registered, so a value is due on bus_rdata at the edge that samples the read strobe. The bench raises the strobe at a falling edge and reads the value at the next falling edge. The flags, busy and irq change at the same edge as the write or final byte that causes them. The first transmit byte is valid from the edge after the closing data-port write. The bench checks irq one half cycle after those edges and checks the other effects through register reads issued afterwards. It captures the transmit stream at each rising edge where valid and ready are both high, and compares the captured bytes with byte values it computes arithmetically from the frame seed.

// File: rtl/nicf_pkg.sv
package nicf_pkg;

  localparam logic [5:0] OFS_ID0   = 6'h00;
  localparam logic [5:0] OFS_ID1   = 6'h04;
  localparam logic [5:0] OFS_BUSY  = 6'h08;
  localparam logic [5:0] OFS_RXCNT = 6'h0C;
  localparam logic [5:0] OFS_TXCNT = 6'h10;
  localparam logic [5:0] OFS_ICTL  = 6'h14;
  localparam logic [5:0] OFS_INFO  = 6'h18;
  localparam logic [5:0] OFS_RXDAT = 6'h1C;
  localparam logic [5:0] OFS_TXDAT = 6'h20;

  localparam logic [31:0] ID_WORD0 = 32'h4D49_5053;
  localparam logic [31:0] ID_WORD1 = 32'h4E45_5430;

  typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_SKIP} rx_mode_e;

  // Programmed transmit length: oversize requests collapse to zero.
  function automatic logic [31:0] clamp_tx_len(input logic [31:0] req,
                                               input logic [31:0] max_len);
    return (req <= max_len) ? req : 32'd0;
  endfunction

  // Stored length once the byte at index idx closes the frame.
  function automatic logic [31:0] rx_len_after(input logic [31:0] idx,
                                               input logic [31:0] max_len);
    return (idx < max_len) ? idx + 32'd1 : max_len;
  endfunction

endpackage

// File: rtl/nicf_ctl.sv
module nicf_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ictl_wr,
  input  logic [2:0]  ictl_bits,   // {bit31, bit1, bit0} of write data
  input  logic        ictl_rd,
  input  logic        tx_fire,
  input  logic        rx_start,
  input  logic        rx_done,
  output logic        soft_rst,
  output logic [31:0] ictl,
  output logic        busy,
  output logic        irq
);

  logic tx_f, rx_f, test_f;
  logic n_tx, n_rx, n_test, n_busy;

  assign soft_rst = ictl_wr && !ictl_bits[0] && !ictl_bits[1] && ictl_bits[2];

  always_comb begin
    n_tx   = tx_f;
    n_rx   = rx_f;
    n_test = test_f;
    n_busy = busy;
    if (ictl_wr) begin
      if (ictl_bits[0])      n_tx = 1'b0;
      else if (ictl_bits[1]) n_rx = 1'b0;
      else if (ictl_bits[2]) begin
        n_tx   = 1'b0;
        n_rx   = 1'b0;
        n_test = 1'b1;
      end
      n_busy = n_tx | n_rx | n_test;
    end else if (ictl_rd) begin
      n_test = 1'b0;
    end
    if (!soft_rst) begin
      if (tx_fire) begin
        n_tx   = 1'b1;
        n_busy = 1'b1;
      end
      if (rx_done) begin
        n_rx   = 1'b1;
        n_busy = 1'b1;
      end
      if (rx_start) n_busy = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_f   <= 1'b0;
      rx_f   <= 1'b0;
      test_f <= 1'b0;
      busy   <= 1'b1;
    end else begin
      tx_f   <= n_tx;
      rx_f   <= n_rx;
      test_f <= n_test;
      busy   <= n_busy;
    end
  end

  assign ictl = {test_f, 29'd0, rx_f, tx_f};
  assign irq  = tx_f | rx_f | test_f;

endmodule

// File: rtl/nicf_rx.sv
module nicf_rx #(
  parameter int MAX_LEN = 1514,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             busy,
  input  logic             pop,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             rx_start,
  output logic             rx_done,
  output logic [LEN_W-1:0] count,
  output logic [7:0]       pop_byte
);
  import nicf_pkg::*;

  localparam int PTR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  logic [7:0]       mem [MAX_LEN];
  rx_mode_e         mode;
  logic [LEN_W-1:0] wptr, rptr;
  logic             fill_byte, store_en, have_data;
  logic [LEN_W-1:0] store_idx, close_len;

  assign have_data = (count != '0);
  assign rx_start  = s_valid && (mode == RX_IDLE) && !busy && !soft_rst && (count < MAX_L);
  assign fill_byte = s_valid && (mode == RX_FILL) && !soft_rst;
  assign rx_done   = (rx_start || fill_byte) && s_last;
  assign store_idx = rx_start ? '0 : wptr;
  assign store_en  = rx_start || (fill_byte && (wptr < MAX_L));
  assign close_len = LEN_W'(rx_len_after(32'(store_idx), 32'(MAX_LEN)));
  assign pop_byte  = have_data ? mem[rptr[PTR_W-1:0]] : 8'd0;

  always_ff @(posedge clk) begin
    if (store_en) mem[store_idx[PTR_W-1:0]] <= s_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= RX_IDLE;
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (soft_rst) begin
      mode  <= RX_IDLE;
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (pop && have_data) begin
        count <= count - LEN_W'(1);
        rptr  <= rptr + LEN_W'(1);
      end
      if (rx_start) begin
        rptr  <= '0;
        wptr  <= LEN_W'(1);
        count <= s_last ? close_len : '0;
        mode  <= s_last ? RX_IDLE : RX_FILL;
      end else if (fill_byte) begin
        if (wptr < MAX_L) wptr <= wptr + LEN_W'(1);
        if (s_last) begin
          count <= close_len;
          rptr  <= '0;
          mode  <= RX_IDLE;
        end
      end else if (s_valid && (mode == RX_IDLE)) begin
        mode <= s_last ? RX_IDLE : RX_SKIP;
      end else if (s_valid && (mode == RX_SKIP) && s_last) begin
        mode <= RX_IDLE;
      end
    end
  end

endmodule

// File: rtl/nicf_tx.sv
module nicf_tx #(
  parameter int MAX_LEN = 1514,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cnt_wr,
  input  logic             dat_wr,
  input  logic [31:0]      wdata,
  input  logic             s_ready,
  output logic [LEN_W-1:0] count,
  output logic             fire,
  output logic             s_valid,
  output logic [7:0]       s_data,
  output logic             s_last
);
  import nicf_pkg::*;

  localparam int PTR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [7:0]       mem [MAX_LEN];
  logic [LEN_W-1:0] wptr, sidx, slen;
  logic             sending, take;

  assign take    = dat_wr && !sending && (wptr < count);
  assign fire    = take && ((wptr + LEN_W'(1)) == count);
  assign s_valid = sending;
  assign s_data  = sending ? mem[sidx[PTR_W-1:0]] : 8'd0;
  assign s_last  = sending && (sidx == slen - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (take) mem[wptr[PTR_W-1:0]] <= wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      wptr  <= '0;
    end else if (soft_rst) begin
      count <= '0;
      wptr  <= '0;
    end else if (cnt_wr) begin
      count <= LEN_W'(clamp_tx_len(wdata, 32'(MAX_LEN)));
      wptr  <= '0;
    end else if (fire) begin
      count <= '0;
      wptr  <= '0;
    end else if (take) begin
      wptr  <= wptr + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending <= 1'b0;
      sidx    <= '0;
      slen    <= '0;
    end else if (fire) begin
      sending <= 1'b1;
      sidx    <= '0;
      slen    <= count;
    end else if (sending && s_ready) begin
      if (s_last) sending <= 1'b0;
      else        sidx    <= sidx + LEN_W'(1);
    end
  end

endmodule

// File: rtl/frame_nic.sv
module frame_nic #(
  parameter int MAX_LEN = 1514,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        rxs_valid,
  input  logic [7:0]  rxs_data,
  input  logic        rxs_last,
  output logic        txs_valid,
  output logic [7:0]  txs_data,
  output logic        txs_last,
  input  logic        txs_ready
);
  import nicf_pkg::*;

  logic             rd_en;
  logic             wr_txcnt, wr_txdat, wr_ictl, rd_ictl, rd_rxdat;
  logic             soft_rst, busy_q, tx_fire, rx_start, rx_done;
  logic [31:0]      ictl_q;
  logic [LEN_W-1:0] rx_cnt, tx_cnt;
  logic [7:0]       pop_byte;

  assign rd_en    = bus_rd && !bus_wr;
  assign wr_txcnt = bus_wr && (bus_addr == OFS_TXCNT);
  assign wr_txdat = bus_wr && (bus_addr == OFS_TXDAT);
  assign wr_ictl  = bus_wr && (bus_addr == OFS_ICTL);
  assign rd_ictl  = rd_en  && (bus_addr == OFS_ICTL);
  assign rd_rxdat = rd_en  && (bus_addr == OFS_RXDAT);

  nicf_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ictl_wr  (wr_ictl),
    .ictl_bits({bus_wdata[31], bus_wdata[1:0]}),
    .ictl_rd  (rd_ictl),
    .tx_fire  (tx_fire),
    .rx_start (rx_start),
    .rx_done  (rx_done),
    .soft_rst (soft_rst),
    .ictl     (ictl_q),
    .busy     (busy_q),
    .irq      (irq)
  );

  nicf_rx #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .busy     (busy_q),
    .pop      (rd_rxdat),
    .s_valid  (rxs_valid),
    .s_data   (rxs_data),
    .s_last   (rxs_last),
    .rx_start (rx_start),
    .rx_done  (rx_done),
    .count    (rx_cnt),
    .pop_byte (pop_byte)
  );

  nicf_tx #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .cnt_wr   (wr_txcnt),
    .dat_wr   (wr_txdat),
    .wdata    (bus_wdata),
    .s_ready  (txs_ready),
    .count    (tx_cnt),
    .fire     (tx_fire),
    .s_valid  (txs_valid),
    .s_data   (txs_data),
    .s_last   (txs_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      case (bus_addr)
        OFS_ID0:   bus_rdata <= ID_WORD0;
        OFS_ID1:   bus_rdata <= ID_WORD1;
        OFS_BUSY:  bus_rdata <= {31'd0, busy_q};
        OFS_RXCNT: bus_rdata <= 32'(rx_cnt);
        OFS_TXCNT: bus_rdata <= 32'(tx_cnt);
        OFS_ICTL:  bus_rdata <= ictl_q;
        OFS_RXDAT: bus_rdata <= {24'd0, pop_byte};
        default:   bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/frame_nic_chk.sv
module frame_nic_chk #(
  parameter int MAX_LEN = 1514,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [5:0]       bus_addr,
  input logic             irq,
  input logic [31:0]      ictl_q,
  input logic             busy_q,
  input logic             tx_fire,
  input logic             rx_done,
  input logic             soft_rst,
  input logic [LEN_W-1:0] rx_cnt,
  input logic [LEN_W-1:0] tx_cnt,
  input logic             txs_valid,
  input logic             txs_ready,
  input logic [7:0]       txs_data,
  input logic             txs_last
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  a_r4_fire_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> (busy_q && ictl_q[0] && tx_cnt == '0));

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txs_valid && !txs_ready) |=> (txs_valid && $stable(txs_data) && $stable(txs_last)));

  a_r7_rx_close: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !soft_rst) |=> (ictl_q[1] && busy_q && rx_cnt != '0));

  a_r8_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= MAX_L);

  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ictl_q == 32'h8000_0000 && busy_q && rx_cnt == '0 && tx_cnt == '0));

  a_r12_test_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 6'h14) |=> !ictl_q[31]);

  a_r13_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tx_fire || rx_done || soft_rst));

endmodule

bind frame_nic frame_nic_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .irq       (irq),
  .ictl_q    (ictl_q),
  .busy_q    (busy_q),
  .tx_fire   (tx_fire),
  .rx_done   (rx_done),
  .soft_rst  (soft_rst),
  .rx_cnt    (rx_cnt),
  .tx_cnt    (tx_cnt),
  .txs_valid (txs_valid),
  .txs_ready (txs_ready),
  .txs_data  (txs_data),
  .txs_last  (txs_last)
);

// File: tb/sim_frame_nic.sv
module sim_frame_nic;
  localparam int ML = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rxs_valid = 1'b0, rxs_last = 1'b0;
  logic [7:0]  rxs_data = '0;
  logic        txs_valid, txs_last;
  logic [7:0]  txs_data;
  logic        txs_ready = 1'b1;

  always #2 clk = ~clk;

  frame_nic #(.MAX_LEN(ML)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rxs_valid(rxs_valid), .rxs_data(rxs_data), .rxs_last(rxs_last),
    .txs_valid(txs_valid), .txs_data(txs_data), .txs_last(txs_last), .txs_ready(txs_ready)
  );

  int n_chk = 0, n_fail = 0;
  int ready_mode = 0;  // 0: always ready, 1: toggling, 2: held low
  logic [7:0] cap_d [64];
  logic       cap_l [64];
  int cap_n = 0;
  logic [31:0] v;

  always @(negedge clk) begin
    if (ready_mode == 0)      txs_ready = 1'b1;
    else if (ready_mode == 1) txs_ready = ~txs_ready;
    else                      txs_ready = 1'b0;
  end

  always @(posedge clk) begin
    if (txs_valid && txs_ready && cap_n < 64) begin
      cap_d[cap_n] = txs_data;
      cap_l[cap_n] = txs_last;
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + 1) % 256);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rx_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rxs_valid = 1'b1; rxs_data = pat(seed, i); rxs_last = (i == len - 1);
    end
    @(negedge clk); rxs_valid = 1'b0; rxs_last = 1'b0;
  endtask

  task automatic load_tx(input int len, input int seed);
    wr(6'h10, 32'(len));
    for (int i = 0; i < len; i++) wr(6'h20, {24'hA5C3E1, pat(seed, i)});
  endtask

  task automatic drain_tx();
    while (txs_valid) @(negedge clk);
  endtask

  task automatic check_cap(input string req, input int len, input int seed, input int off);
    check(req, 32'(cap_n), 32'(len));
    for (int i = 0; i < len; i++) begin
      check(req, {24'd0, cap_d[i]}, {24'd0, pat(seed, i + off)});
      check(req, {31'd0, cap_l[i]}, {31'd0, (i == len - 1)});
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R14 hard reset state
    check("R13 irq at reset", {31'd0, irq}, 32'd0);
    rd(6'h08, v); check("R14 busy", v, 32'd1);
    rd(6'h14, v); check("R14 ictl", v, 32'd0);
    rd(6'h0C, v); check("R14 rx count", v, 32'd0);
    rd(6'h10, v); check("R14 tx count", v, 32'd0);

    // R1 fixed reads
    rd(6'h00, v); check("R1 id0", v, 32'h4D495053);
    rd(6'h04, v); check("R1 id1", v, 32'h4E455430);
    rd(6'h18, v); check("R1 info", v, 32'd0);
    rd(6'h20, v); check("R1 txdat", v, 32'd0);

    // R2 read-only offsets ignore writes
    wr(6'h08, 32'd0);  rd(6'h08, v); check("R2 busy write", v, 32'd1);
    wr(6'h0C, 32'd5);  rd(6'h0C, v); check("R2 rxcnt write", v, 32'd0);
    wr(6'h00, 32'd7);  rd(6'h00, v); check("R2 id write", v, 32'h4D495053);
    wr(6'h18, 32'd9);  rd(6'h18, v); check("R2 info write", v, 32'd0);
    wr(6'h1C, 32'd3);  rd(6'h0C, v); check("R2 rxdat write", v, 32'd0);

    // R6 frame dropped while busy
    rx_frame(3, 1);
    rd(6'h0C, v); check("R6 drop busy cnt", v, 32'd0);
    rd(6'h14, v); check("R6 drop busy ictl", v, 32'd0);

    // R11 write zero recomputes busy
    wr(6'h14, 32'd0); rd(6'h08, v); check("R11 busy released", v, 32'd0);

    // R7 R8 R9 receive sweep
    for (int len = 1; len <= ML + 3; len++) begin
      int exp_n;
      exp_n = (len < ML) ? len : ML;
      rx_frame(len, len);
      check("R13 irq rx", {31'd0, irq}, 32'd1);
      rd(6'h0C, v); check("R7 R8 rx count", v, 32'(exp_n));
      rd(6'h14, v); check("R7 rxdone", v, 32'd2);
      rd(6'h08, v); check("R7 busy", v, 32'd1);
      rx_frame(2, 77);
      rd(6'h0C, v); check("R6 drop keeps count", v, 32'(exp_n));
      for (int i = 0; i < exp_n; i++) begin
        rd(6'h1C, v); check("R9 rx byte", v, {24'd0, pat(len, i)});
      end
      rd(6'h1C, v); check("R9 empty read", v, 32'd0);
      rd(6'h0C, v); check("R9 count drained", v, 32'd0);
      wr(6'h14, 32'd2);
      check("R13 irq cleared", {31'd0, irq}, 32'd0);
      rd(6'h08, v); check("R11 busy after rx clear", v, 32'd0);
    end

    // R6 full buffer blocks acceptance
    rx_frame(ML + 2, 5);
    wr(6'h14, 32'd2);
    rx_frame(2, 9);
    rd(6'h0C, v); check("R6 full count", v, 32'(ML));
    rd(6'h14, v); check("R6 full no flag", v, 32'd0);
    for (int i = 0; i < ML; i++) begin
      rd(6'h1C, v); check("R8 truncated byte", v, {24'd0, pat(5, i)});
    end

    // R4 R5 transmit sweep
    for (int len = 1; len <= ML; len++) begin
      ready_mode = len % 2;
      cap_n = 0;
      load_tx(len, len + 40);
      drain_tx();
      check_cap("R5 tx stream", len, len + 40, 0);
      check("R13 irq tx", {31'd0, irq}, 32'd1);
      rd(6'h14, v); check("R4 txdone", v, 32'd1);
      rd(6'h08, v); check("R4 busy", v, 32'd1);
      rd(6'h10, v); check("R4 count zero", v, 32'd0);
      wr(6'h14, 32'd1);
      rd(6'h08, v); check("R11 busy after tx clear", v, 32'd0);
    end
    ready_mode = 0;

    // R3 count clamp and pointer restart
    wr(6'h10, 32'(ML + 1)); rd(6'h10, v); check("R3 clamp", v, 32'd0);
    wr(6'h10, 32'(ML));     rd(6'h10, v); check("R3 max", v, 32'(ML));
    wr(6'h10, 32'hFFFF_0003); rd(6'h10, v); check("R3 wide", v, 32'd0);
    wr(6'h20, 32'd99);
    rd(6'h14, v); check("R4 zero count write dropped", v, 32'd0);
    cap_n = 0;
    wr(6'h10, 32'd3);
    wr(6'h20, 32'(pat(60, 0)));
    load_tx(2, 61);
    drain_tx();
    check_cap("R3 pointer restart", 2, 61, 0);
    wr(6'h14, 32'd1);

    // R5 data writes ignored while streaming
    ready_mode = 2;
    cap_n = 0;
    load_tx(2, 70);
    wr(6'h10, 32'd2);
    wr(6'h20, 32'd11);
    wr(6'h20, 32'd12);
    rd(6'h10, v); check("R5 writes ignored count", v, 32'd2);
    ready_mode = 0;
    @(negedge clk);
    drain_tx();
    check_cap("R5 stalled frame", 2, 70, 0);
    cap_n = 0;
    wr(6'h20, 32'(pat(70, 5)));
    wr(6'h20, 32'(pat(70, 6)));
    @(negedge clk);
    drain_tx();
    check_cap("R5 next frame", 2, 70, 5);
    wr(6'h14, 32'd1);

    // R10 priority of clears
    rx_frame(2, 3);
    load_tx(1, 4);
    drain_tx();
    rd(6'h14, v); check("R10 both set", v, 32'd3);
    wr(6'h14, 32'd3);
    rd(6'h14, v); check("R10 bit0 first", v, 32'd2);
    rd(6'h08, v); check("R11 busy kept", v, 32'd1);
    load_tx(1, 4);
    drain_tx();
    wr(6'h14, 32'h8000_0002);
    rd(6'h14, v); check("R10 bit1 before bit31", v, 32'd1);
    wr(6'h14, 32'd0);
    rd(6'h14, v); check("R10 zero acks only", v, 32'd1);
    wr(6'h14, 32'd1);
    rd(6'h08, v); check("R11 busy clear", v, 32'd0);

    // R10 R12 R14 soft reset
    rx_frame(4, 8);
    wr(6'h14, 32'd2);
    wr(6'h10, 32'd5);
    wr(6'h14, 32'h8000_0000);
    check("R13 irq test", {31'd0, irq}, 32'd1);
    rd(6'h08, v); check("R14 soft busy", v, 32'd1);
    rd(6'h0C, v); check("R14 soft rx count", v, 32'd0);
    rd(6'h10, v); check("R14 soft tx count", v, 32'd0);
    rd(6'h1C, v); check("R9 empty after soft", v, 32'd0);
    rd(6'h14, v); check("R12 read value", v, 32'h8000_0000);
    rd(6'h14, v); check("R12 cleared", v, 32'd0);
    check("R13 irq after read", {31'd0, irq}, 32'd0);
    rd(6'h08, v); check("R11 busy until write", v, 32'd1);
    wr(6'h14, 32'd0);
    rd(6'h08, v); check("R11 busy after ack", v, 32'd0);

    finish_run();
  end
endmodule